// File: doc/BRIEF.md
# Threshold-Stepped Supply Voltage Controller

This block closes a loop around an on-chip delay sensor and a supply DAC. At a fixed interval it samples the sensor reading and builds a working threshold: the largest of four calibrated limits, plus a safety margin. It subtracts that threshold from the reading and moves a digital voltage setpoint by a step chosen from the size of the difference. A large surplus of sensor speed gives a coarse step down. A small surplus gives a fine step down. A reading exactly at the threshold holds the setpoint. Any reading below the threshold gives a step up.

The setpoint is an unsigned code with a 5 mV LSB. After reset it starts from a programmable initial code. Every new value is clamped between a programmable floor and a programmable ceiling. Each time the setpoint is written, a one-cycle strobe tells the DAC interface to take the new code. The update interval comes from a prescaler whose length in clock cycles is a parameter. The default gives 200 ms at 50 MHz, and a short interval is used in simulation.

Top module: `vstep_ctrl`

## Requirements
- R1: While reset is held, `voltValid` is low. The first `voltValid` pulse after reset carries `initCode`, clamped into [`minCode`, `maxCode`].
- R2: The working threshold is the maximum of `limStaticDelay`, `limDynDelay`, `limStaticIo` and `limDynIo`, plus `safetyMargin`. The difference is `sensorCode` minus this threshold.
- R3: When the difference is greater than 8, the next update lowers `voltCode` by 10 codes (50 mV).
- R4: When the difference is in 4..8, the next update lowers `voltCode` by 2 codes (10 mV).
- R5: When the difference is in 1..3, the next update lowers `voltCode` by 1 code (5 mV).
- R6: When the difference is exactly 0, the next update leaves `voltCode` unchanged, and `voltValid` still pulses.
- R7: When the difference is negative, the next update raises `voltCode` by 2 codes (10 mV). This holds for the most negative difference: reading 0, every limit 255, margin 15.
- R8: Every value written to `voltCode` lies in [`minCode`, `maxCode`]. A step that would cross a bound lands on that bound.
- R9: `voltValid` is high for exactly one cycle per update. From the first regular update on, consecutive pulses are exactly `TICK_CYCLES` cycles apart.
- R10: `voltCode` changes only in a cycle in which `voltValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sensorCode | input | 8 | Delay sensor reading; larger means faster logic |
| limStaticDelay | input | 8 | Calibrated limit for slow-changing timing failure |
| limDynDelay | input | 8 | Calibrated limit for fast-changing timing failure |
| limStaticIo | input | 8 | Calibrated limit for slow-changing output-drive failure |
| limDynIo | input | 8 | Calibrated limit for fast-changing output-drive failure |
| safetyMargin | input | 4 | Margin added to the largest limit (2 recommended) |
| initCode | input | 9 | Setpoint loaded after reset, 5 mV per code (360 = 1.8 V) |
| minCode | input | 9 | Lowest permitted setpoint code |
| maxCode | input | 9 | Highest permitted setpoint code |
| voltCode | output | 9 | Supply setpoint for the DAC, 5 mV per code |
| voltValid | output | 1 | One-cycle strobe marking a newly written `voltCode` |

## Verification
The checker watches four properties on every cycle. The strobe is silent in reset and never lasts longer than one cycle. The setpoint only moves when the strobe fires and stays inside its bounds. Strobe spacing equals the prescaler length once regular updates run. The amount of each step cannot be seen from the ports alone within a single cycle, so the directed scenarios cover it. They place the reading on every band edge (differences 9, 8, 4, 3, 1, 0, −1 and the most negative). They move the largest limit to a different input and change the margin. They push the setpoint into both bounds and reload an out-of-range initial code through a second reset.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // take the clamped initial code
    logic capture;  // register the reading-minus-threshold difference
    logic apply;    // step the setpoint from the captured difference
  } strobes_t;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_WAIT,
    ST_EVAL,
    ST_APPLY
  } ctrlState_t;

  typedef enum logic [2:0] {
    CLS_HOLD,
    CLS_UP,
    CLS_DN_SMALL,
    CLS_DN_MID,
    CLS_DN_BIG
  } stepCls_t;

endpackage

// File: rtl/vstep_timer.sv
module vstep_timer #(
  parameter int TICK_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == LAST) begin
      count <= '0;
      tick  <= 1'b1;
    end else begin
      count <= count + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
  import vstep_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  output strobes_t strobes
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_INIT: begin
        strobes.load = 1'b1;
        stateNext    = ST_WAIT;
      end
      ST_WAIT: begin
        if (tick) stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        strobes.capture = 1'b1;
        stateNext       = ST_APPLY;
      end
      ST_APPLY: begin
        strobes.apply = 1'b1;
        stateNext     = ST_WAIT;
      end
      default: stateNext = ST_INIT;
    endcase
  end
endmodule

// File: rtl/vstep_datapath.sv
module vstep_datapath
  import vstep_pkg::*;
#(
  parameter int SENSOR_W   = 8,
  parameter int MARGIN_W   = 4,
  parameter int CODE_W     = 9,
  parameter int NUM_LIMITS = 4,
  parameter int BIG_BAND   = 8,
  parameter int MID_BAND   = 3,
  parameter int BIG_DN     = 10,
  parameter int MID_DN     = 2,
  parameter int SMALL_DN   = 1,
  parameter int UP_STEP    = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  strobes_t                             strobes,
  input  logic [SENSOR_W-1:0]                  sensorCode,
  input  logic [NUM_LIMITS-1:0][SENSOR_W-1:0]  limits,
  input  logic [MARGIN_W-1:0]                  safetyMargin,
  input  logic [CODE_W-1:0]                    initCode,
  input  logic [CODE_W-1:0]                    minCode,
  input  logic [CODE_W-1:0]                    maxCode,
  output logic [CODE_W-1:0]                    voltCode,
  output logic                                 voltValid
);
  // Threshold needs one bit over the sensor; the difference one more for sign.
  localparam int THR_W  = SENSOR_W + 1;
  localparam int DIFF_W = THR_W + 1;
  localparam int SUM_W  = CODE_W + 2;

  // Running maximum over the calibrated limits.
  logic [SENSOR_W-1:0] runMax [NUM_LIMITS];
  assign runMax[0] = limits[0];
  for (genvar g = 1; g < NUM_LIMITS; g++) begin : g_max
    assign runMax[g] = (limits[g] > runMax[g-1]) ? limits[g] : runMax[g-1];
  end

  logic [THR_W-1:0]         threshold;
  logic signed [DIFF_W-1:0] diffNow;
  logic signed [DIFF_W-1:0] diffReg;

  assign threshold = {1'b0, runMax[NUM_LIMITS-1]} + THR_W'(safetyMargin);
  assign diffNow   = $signed({2'b00, sensorCode}) - $signed({1'b0, threshold});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               diffReg <= '0;
    else if (strobes.capture) diffReg <= diffNow;
  end

  // Band classification of the captured difference.
  stepCls_t cls;
  always_comb begin
    if (diffReg > $signed(DIFF_W'(BIG_BAND)))      cls = CLS_DN_BIG;
    else if (diffReg > $signed(DIFF_W'(MID_BAND))) cls = CLS_DN_MID;
    else if (diffReg > $signed(DIFF_W'(0)))        cls = CLS_DN_SMALL;
    else if (diffReg == $signed(DIFF_W'(0)))       cls = CLS_HOLD;
    else                                           cls = CLS_UP;
  end

  logic signed [SUM_W-1:0] delta;
  always_comb begin
    unique case (cls)
      CLS_DN_BIG:   delta = -$signed(SUM_W'(BIG_DN));
      CLS_DN_MID:   delta = -$signed(SUM_W'(MID_DN));
      CLS_DN_SMALL: delta = -$signed(SUM_W'(SMALL_DN));
      CLS_UP:       delta =  $signed(SUM_W'(UP_STEP));
      default:      delta = '0;
    endcase
  end

  function automatic logic [CODE_W-1:0] clampCode(
    input logic signed [SUM_W-1:0] cand,
    input logic [CODE_W-1:0]       lo,
    input logic [CODE_W-1:0]       hi
  );
    if (cand < $signed({2'b00, lo}))      return lo;
    else if (cand > $signed({2'b00, hi})) return hi;
    else                                  return cand[CODE_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] stepped;
  logic [CODE_W-1:0]       stepClamped;
  logic [CODE_W-1:0]       initClamped;

  assign stepped     = $signed({2'b00, voltCode}) + delta;
  assign stepClamped = clampCode(stepped, minCode, maxCode);
  assign initClamped = clampCode($signed({2'b00, initCode}), minCode, maxCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voltCode  <= '0;
      voltValid <= 1'b0;
    end else begin
      voltValid <= strobes.load | strobes.apply;
      if (strobes.load)       voltCode <= initClamped;
      else if (strobes.apply) voltCode <= stepClamped;
    end
  end
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int TICK_CYCLES = 10_000_000,
  parameter int SENSOR_W    = 8,
  parameter int MARGIN_W    = 4,
  parameter int CODE_W      = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SENSOR_W-1:0] sensorCode,
  input  logic [SENSOR_W-1:0] limStaticDelay,
  input  logic [SENSOR_W-1:0] limDynDelay,
  input  logic [SENSOR_W-1:0] limStaticIo,
  input  logic [SENSOR_W-1:0] limDynIo,
  input  logic [MARGIN_W-1:0] safetyMargin,
  input  logic [CODE_W-1:0]   initCode,
  input  logic [CODE_W-1:0]   minCode,
  input  logic [CODE_W-1:0]   maxCode,
  output logic [CODE_W-1:0]   voltCode,
  output logic                voltValid
);
  localparam int NUM_LIMITS = 4;

  logic                                tick;
  strobes_t                            strobes;
  logic [NUM_LIMITS-1:0][SENSOR_W-1:0] limits;

  assign limits = {limDynIo, limStaticIo, limDynDelay, limStaticDelay};

  vstep_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  vstep_seq u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .strobes (strobes)
  );

  vstep_datapath #(
    .SENSOR_W   (SENSOR_W),
    .MARGIN_W   (MARGIN_W),
    .CODE_W     (CODE_W),
    .NUM_LIMITS (NUM_LIMITS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .sensorCode   (sensorCode),
    .limits       (limits),
    .safetyMargin (safetyMargin),
    .initCode     (initCode),
    .minCode      (minCode),
    .maxCode      (maxCode),
    .voltCode     (voltCode),
    .voltValid    (voltValid)
  );
endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk #(
  parameter int TICK_CYCLES = 10_000_000,
  parameter int CODE_W      = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] minCode,
  input logic [CODE_W-1:0] maxCode,
  input logic [CODE_W-1:0] voltCode,
  input logic              voltValid
);
  logic [31:0] gap;
  logic [1:0]  seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap  <= '0;
      seen <= '0;
    end else if (voltValid) begin
      gap <= 32'd1;
      if (seen != 2'd3) seen <= seen + 2'd1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  // R1: no strobe while reset is held.
  p_quiet_reset_r1: assert property (@(posedge clk) !rstN |-> !voltValid);

  // R9: strobe lasts one cycle.
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    voltValid |=> !voltValid);

  // R9: regular spacing once stepping has begun.
  p_interval_r9: assert property (@(posedge clk) disable iff (!rstN)
    (voltValid && seen >= 2'd2) |-> gap == 32'(TICK_CYCLES));

  // R10: setpoint only moves with a strobe.
  p_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !voltValid |-> $stable(voltCode));

  // R8: written value inside the bounds.
  p_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (voltValid && minCode <= maxCode) |-> (voltCode >= minCode && voltCode <= maxCode));
endmodule

bind vstep_ctrl vstep_ctrl_chk #(
  .TICK_CYCLES (TICK_CYCLES),
  .CODE_W      (CODE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .minCode   (minCode),
  .maxCode   (maxCode),
  .voltCode  (voltCode),
  .voltValid (voltValid)
);

// File: tb/vstep_ctrl_test.sv
`timescale 1ns/1ps
module vstep_ctrl_test;
  localparam int TICK = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sensorCode = 8'd0;
  logic [7:0] limStaticDelay = 8'd60, limDynDelay = 8'd70;
  logic [7:0] limStaticIo = 8'd50, limDynIo = 8'd65;
  logic [3:0] safetyMargin = 4'd2;
  logic [8:0] initCode = 9'd360, minCode = 9'd200, maxCode = 9'd400;
  logic [8:0] voltCode;
  logic       voltValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vstep_ctrl #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rstN(rstN), .sensorCode(sensorCode),
    .limStaticDelay(limStaticDelay), .limDynDelay(limDynDelay),
    .limStaticIo(limStaticIo), .limDynIo(limDynIo),
    .safetyMargin(safetyMargin), .initCode(initCode),
    .minCode(minCode), .maxCode(maxCode),
    .voltCode(voltCode), .voltValid(voltValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for the next strobe (sampled at falling edges); returns cycles waited.
  task automatic nextPulse(output int waited);
    waited = 0;
    forever begin
      @(negedge clk);
      waited++;
      if (voltValid) break;
      if (waited > 5 * TICK) begin
        errors++;
        $display("FAIL R9: actual=no strobe expected=strobe within %0d cycles", 5 * TICK);
        break;
      end
    end
  endtask

  task automatic stepTo(input string req, input int sensor, input int expCode);
    int w;
    sensorCode = 8'(sensor);
    nextPulse(w);
    check(req, int'(voltCode), expCode);
  endtask

  task automatic doReset(input int initVal);
    int w;
    @(negedge clk);
    rstN = 1'b0;
    initCode = 9'(initVal);
    repeat (3) @(negedge clk);
    check("R1 quiet in reset", int'(voltValid), 0);
    rstN = 1'b1;
    nextPulse(w);
  endtask

  task automatic t_reset_init();
    doReset(360);
    check("R1 initial code", int'(voltCode), 360);
  endtask

  task automatic t_bands();
    // threshold = max(60,70,50,65) + 2 = 72
    stepTo("R3 diff 9", 81, 350);
    stepTo("R4 diff 8", 80, 348);
    stepTo("R4 diff 4", 76, 346);
    stepTo("R5 diff 3", 75, 345);
    stepTo("R5 diff 1", 73, 344);
    stepTo("R6 diff 0", 72, 344);
    stepTo("R7 diff -1", 71, 346);
  endtask

  task automatic t_no_wrap();
    limStaticDelay = 8'd255; limDynDelay = 8'd255;
    limStaticIo = 8'd255; limDynIo = 8'd255; safetyMargin = 4'd15;
    stepTo("R7 most negative", 0, 348);
  endtask

  task automatic t_threshold_source();
    limStaticDelay = 8'd60; limDynDelay = 8'd70;
    limStaticIo = 8'd50; limDynIo = 8'd100; safetyMargin = 4'd2;
    stepTo("R2 largest on last limit, diff 0", 102, 348);
    stepTo("R2 diff 1", 103, 347);
    safetyMargin = 4'd0;
    stepTo("R2 margin 0, diff 2", 102, 346);
  endtask

  task automatic t_clamp();
    maxCode = 9'd347;
    stepTo("R8 ceiling", 0, 347);
    stepTo("R8 ceiling held", 0, 347);
    minCode = 9'd340;
    stepTo("R8 floor", 255, 340);
  endtask

  task automatic t_interval();
    int w;
    sensorCode = 8'd100;   // diff 0 with threshold 100: hold
    nextPulse(w);
    nextPulse(w);
    check("R9 strobe spacing", w, TICK);
    check("R10 held code", int'(voltCode), 340);
    @(negedge clk);
    check("R9 one-cycle strobe", int'(voltValid), 0);
  endtask

  task automatic t_init_clamp();
    minCode = 9'd200; maxCode = 9'd400;
    doReset(500);
    check("R1 R8 initial code clamped", int'(voltCode), 400);
  endtask

  initial begin
    t_reset_init();
    t_bands();
    t_no_wrap();
    t_threshold_source();
    t_clamp();
    t_interval();
    t_init_clamp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule